// File: doc/BRIEF.md
# Workgroup Grid Dispatch Sequencer

The sequencer accepts a kernel launch descriptor: a three-dimensional grid extent, a three-dimensional workgroup extent and two register-count fields. From these it works out how many workgroups each dimension holds and how many the kernel holds in all. It then hands out workgroups one at a time over a valid/ready handshake. Each workgroup carries its X, Y and Z coordinates and a flat running index. The walk advances X first, then Y, then Z.

A grid extent does not have to be a multiple of the workgroup extent. The last workgroup along a dimension may then be partial, and it is still issued. After the final workgroup leaves, the sequencer raises a dispatch-complete flag. Downstream logic reports each finished workgroup back. Once every issued workgroup has been reported, the block raises a one-cycle kernel-finished pulse and returns to idle, ready for the next descriptor.

At load the block also latches a per-workitem vector register budget and a per-wave scalar register budget. When the explicit count in the descriptor is zero, each budget is rebuilt from a coarse granule field.

Top module: `wg_grid_sequencer`

## Requirements
- R1: After reset, `wg_valid`, `disp_done`, `kernel_done` and `cfg_err` are all 0.
- R2: A load that is accepted latches, one cycle later, the per-dimension workgroup counts `num_wg_*`. Each count is ceil(grid extent / workgroup extent). The same load latches `num_wg_total`, the product of the three counts. It also sets all workgroup coordinates and `wg_flat` to 0.
- R3: Each accepted handshake (`wg_valid` and `wg_ready` both 1 at a clock edge) moves `wg_flat` up by one. It also moves the coordinates in X-fastest order. X wraps to 0 and Y increments once X+1 reaches the X count. Y wraps into Z in the same way. Partial edge workgroups are issued.
- R4: While `wg_valid` is 1 and `wg_ready` is 0, `wg_valid`, the three coordinates and `wg_flat` hold their values.
- R5: Accepting the workgroup with the highest coordinates in all three dimensions sets `disp_done` on that edge. From then on, `wg_valid` is 0.
- R6: A load pulse while a kernel is running has no effect. It changes neither the counts nor the coordinates.
- R7: `vreg_budget` equals `vreg_explicit` when that input is nonzero. Otherwise it equals (`vreg_granule` + 1) × 4.
- R8: `sreg_budget` equals `sreg_explicit` when that input is nonzero. Otherwise it equals (`sreg_granule` + 1) × 8.
- R9: Each `wg_done` pulse while running adds one to a completion count. `kernel_done` is 1 for exactly one cycle, on the clock after the count has reached `num_wg_total` with `disp_done` set. It is never 1 before that point, and afterwards the sequencer accepts a new load.
- R10: A load with a zero workgroup extent or a zero grid extent in any dimension sets `cfg_err` and keeps `wg_valid` at 0. A later valid load clears `cfg_err` and starts dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Descriptor load pulse |
| grid_x | input | SIZE_W | Grid extent, X |
| grid_y | input | SIZE_W | Grid extent, Y |
| grid_z | input | SIZE_W | Grid extent, Z |
| wgsz_x | input | SIZE_W | Workgroup extent, X |
| wgsz_y | input | SIZE_W | Workgroup extent, Y |
| wgsz_z | input | SIZE_W | Workgroup extent, Z |
| vreg_explicit | input | REG_W | Explicit vector registers per workitem |
| vreg_granule | input | VGRAN_W | Granule-encoded vector register count |
| sreg_explicit | input | REG_W | Explicit scalar registers per wave |
| sreg_granule | input | SGRAN_W | Granule-encoded scalar register count |
| wg_ready | input | 1 | Consumer accepts the offered workgroup |
| wg_done | input | 1 | One workgroup has finished |
| wg_valid | output | 1 | A workgroup is offered |
| wg_id_x | output | CNT_W | Workgroup coordinate, X |
| wg_id_y | output | CNT_W | Workgroup coordinate, Y |
| wg_id_z | output | CNT_W | Workgroup coordinate, Z |
| wg_flat | output | CNT_W | Flat workgroup index |
| num_wg_x | output | CNT_W | Workgroups along X |
| num_wg_y | output | CNT_W | Workgroups along Y |
| num_wg_z | output | CNT_W | Workgroups along Z |
| num_wg_total | output | CNT_W | Workgroups in the kernel |
| vreg_budget | output | REG_W | Vector register budget |
| sreg_budget | output | REG_W | Scalar register budget |
| disp_done | output | 1 | All workgroups issued |
| kernel_done | output | 1 | One-cycle kernel-finished pulse |
| cfg_err | output | 1 | Last load had a zero extent |

## Verification
The bench builds the block with SIZE_W=16, CNT_W=16, REG_W=12, VGRAN_W=6 and SGRAN_W=4. These narrow widths let the bench drive both granule fields at their all-ones values, so the largest fallback budgets (256 and 128) are exercised. Small grids such as 5×3×2 with 2×2×1 workgroups bring partial edge workgroups and both wrap steps into a short walk. A single-workgroup kernel, in which X, Y and Z all wrap on the first handshake, is also within reach.

// File: rtl/wgs_pkg.sv
package wgs_pkg;

    localparam int NDIM          = 3;
    localparam int VREG_GRANULE  = 4;
    localparam int SREG_GRANULE  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_FAULT = 2'd2
    } seq_state_e;

    // Ceiling division; a zero divisor yields zero (caller flags it).
    function automatic logic [63:0] ceil_div(input logic [63:0] num,
                                             input logic [63:0] den);
        logic [63:0] q;
        if (den == 64'd0) begin
            return 64'd0;
        end
        q = num / den;
        if ((num % den) != 64'd0) begin
            q = q + 64'd1;
        end
        return q;
    endfunction

endpackage

// File: rtl/wgs_dim_ctr.sv
module wgs_dim_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] bound,
    output logic [CNT_W-1:0] id,
    output logic             wrap
);
    logic [CNT_W:0] nxt;

    assign nxt  = {1'b0, id} + (CNT_W+1)'(1);
    assign wrap = step && (nxt >= {1'b0, bound});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            id <= '0;
        end else if (step) begin
            id <= wrap ? '0 : nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/wgs_reg_budget.sv
module wgs_reg_budget #(
    parameter int REG_W  = 16,
    parameter int GRAN_W = 6,
    parameter int MUL    = 4
) (
    input  logic [REG_W-1:0]  explicit_cnt,
    input  logic [GRAN_W-1:0] granule,
    output logic [REG_W-1:0]  budget
);
    logic [REG_W-1:0] gran_ext;
    logic [REG_W-1:0] scaled;

    assign gran_ext = REG_W'(granule);
    assign scaled   = (gran_ext + REG_W'(1)) * REG_W'(MUL);
    assign budget   = (explicit_cnt != '0) ? explicit_cnt : scaled;
endmodule

// File: rtl/wgs_done_tracker.sv
module wgs_done_tracker #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             done_in,
    input  logic             disp_done,
    input  logic [CNT_W-1:0] total,
    output logic             finish,
    output logic             kernel_done
);
    logic [CNT_W-1:0] done_cnt;

    assign finish = run && disp_done && (done_cnt == total);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            done_cnt <= '0;
        end else if (run && done_in && (done_cnt != total)) begin
            done_cnt <= done_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kernel_done <= 1'b0;
        end else begin
            kernel_done <= finish;
        end
    end
endmodule

// File: rtl/wg_grid_sequencer.sv
module wg_grid_sequencer
    import wgs_pkg::*;
#(
    parameter int SIZE_W  = 32,
    parameter int CNT_W   = 32,
    parameter int REG_W   = 16,
    parameter int VGRAN_W = 6,
    parameter int SGRAN_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SIZE_W-1:0]  grid_x,
    input  logic [SIZE_W-1:0]  grid_y,
    input  logic [SIZE_W-1:0]  grid_z,
    input  logic [SIZE_W-1:0]  wgsz_x,
    input  logic [SIZE_W-1:0]  wgsz_y,
    input  logic [SIZE_W-1:0]  wgsz_z,
    input  logic [REG_W-1:0]   vreg_explicit,
    input  logic [VGRAN_W-1:0] vreg_granule,
    input  logic [REG_W-1:0]   sreg_explicit,
    input  logic [SGRAN_W-1:0] sreg_granule,
    input  logic               wg_ready,
    input  logic               wg_done,
    output logic               wg_valid,
    output logic [CNT_W-1:0]   wg_id_x,
    output logic [CNT_W-1:0]   wg_id_y,
    output logic [CNT_W-1:0]   wg_id_z,
    output logic [CNT_W-1:0]   wg_flat,
    output logic [CNT_W-1:0]   num_wg_x,
    output logic [CNT_W-1:0]   num_wg_y,
    output logic [CNT_W-1:0]   num_wg_z,
    output logic [CNT_W-1:0]   num_wg_total,
    output logic [REG_W-1:0]   vreg_budget,
    output logic [REG_W-1:0]   sreg_budget,
    output logic               disp_done,
    output logic               kernel_done,
    output logic               cfg_err
);
    localparam int LAST = NDIM - 1;

    logic [NDIM-1:0][SIZE_W-1:0] grid_in;
    logic [NDIM-1:0][SIZE_W-1:0] size_in;
    logic [NDIM-1:0][CNT_W-1:0]  num_calc;
    logic [NDIM-1:0][CNT_W-1:0]  num_q;
    logic [NDIM-1:0][CNT_W-1:0]  id_q;
    logic [NDIM-1:0]             zero_dim;
    logic [NDIM-1:0]             step;
    logic [NDIM-1:0]             wrap;

    seq_state_e       state_q;
    logic             load_ok;
    logic             bad_desc;
    logic             fire;
    logic             done_q;
    logic             finish;
    logic [CNT_W-1:0] flat_q;
    logic [CNT_W-1:0] total_calc;
    logic [CNT_W-1:0] total_q;
    logic [REG_W-1:0] vbud_calc;
    logic [REG_W-1:0] sbud_calc;
    logic [REG_W-1:0] vbud_q;
    logic [REG_W-1:0] sbud_q;

    assign grid_in = {grid_z, grid_y, grid_x};
    assign size_in = {wgsz_z, wgsz_y, wgsz_x};

    // Per-dimension count, fault detect and coordinate counters.
    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        assign num_calc[d] = CNT_W'(ceil_div(64'(grid_in[d]), 64'(size_in[d])));
        assign zero_dim[d] = (grid_in[d] == '0) || (size_in[d] == '0);

        if (d == 0) begin : g_first
            assign step[d] = fire;
        end else begin : g_chain
            assign step[d] = wrap[d-1];
        end

        wgs_dim_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .clr   (load_ok),
            .step  (step[d]),
            .bound (num_q[d]),
            .id    (id_q[d]),
            .wrap  (wrap[d])
        );
    end

    assign total_calc = num_calc[0] * num_calc[1] * num_calc[2];
    assign bad_desc   = |zero_dim;
    assign load_ok    = load && (state_q != SEQ_RUN);
    assign wg_valid   = (state_q == SEQ_RUN) && !done_q;
    assign fire       = wg_valid && wg_ready;

    wgs_reg_budget #(.REG_W(REG_W), .GRAN_W(VGRAN_W), .MUL(VREG_GRANULE)) u_vbud (
        .explicit_cnt (vreg_explicit),
        .granule      (vreg_granule),
        .budget       (vbud_calc)
    );

    wgs_reg_budget #(.REG_W(REG_W), .GRAN_W(SGRAN_W), .MUL(SREG_GRANULE)) u_sbud (
        .explicit_cnt (sreg_explicit),
        .granule      (sreg_granule),
        .budget       (sbud_calc)
    );

    wgs_done_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .clr         (load_ok),
        .run         (state_q == SEQ_RUN),
        .done_in     (wg_done),
        .disp_done   (done_q),
        .total       (total_q),
        .finish      (finish),
        .kernel_done (kernel_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            num_q   <= '0;
            total_q <= '0;
            vbud_q  <= '0;
            sbud_q  <= '0;
            done_q  <= 1'b0;
            flat_q  <= '0;
        end else if (load_ok) begin
            state_q <= bad_desc ? SEQ_FAULT : SEQ_RUN;
            num_q   <= num_calc;
            total_q <= total_calc;
            vbud_q  <= vbud_calc;
            sbud_q  <= sbud_calc;
            done_q  <= 1'b0;
            flat_q  <= '0;
        end else begin
            if (fire) begin
                flat_q <= flat_q + CNT_W'(1);
            end
            if (wrap[LAST]) begin
                done_q <= 1'b1;
            end
            if (finish) begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    assign wg_id_x      = id_q[0];
    assign wg_id_y      = id_q[1];
    assign wg_id_z      = id_q[2];
    assign wg_flat      = flat_q;
    assign num_wg_x     = num_q[0];
    assign num_wg_y     = num_q[1];
    assign num_wg_z     = num_q[2];
    assign num_wg_total = total_q;
    assign vreg_budget  = vbud_q;
    assign sreg_budget  = sbud_q;
    assign disp_done    = done_q;
    assign cfg_err      = (state_q == SEQ_FAULT);
endmodule

// File: rtl/wgs_checker.sv
module wgs_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             wg_valid,
    input logic             wg_ready,
    input logic [CNT_W-1:0] wg_id_x,
    input logic [CNT_W-1:0] wg_id_y,
    input logic [CNT_W-1:0] wg_id_z,
    input logic [CNT_W-1:0] wg_flat,
    input logic [CNT_W-1:0] num_wg_x,
    input logic [CNT_W-1:0] num_wg_y,
    input logic [CNT_W-1:0] num_wg_z,
    input logic [CNT_W-1:0] num_wg_total,
    input logic             disp_done,
    input logic             kernel_done,
    input logic             cfg_err
);
    a_r3_ids_in_range: assert property (@(posedge clk) disable iff (rst)
        wg_valid |-> (wg_id_x < num_wg_x) && (wg_id_y < num_wg_y) &&
                     (wg_id_z < num_wg_z) && (wg_flat < num_wg_total));

    a_r3_flat_step: assert property (@(posedge clk) disable iff (rst)
        (wg_valid && wg_ready) |=> (wg_flat == $past(wg_flat) + CNT_W'(1)));

    a_r4_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (wg_valid && !wg_ready) |=> wg_valid && $stable(wg_id_x) &&
            $stable(wg_id_y) && $stable(wg_id_z) && $stable(wg_flat));

    a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        disp_done |-> !wg_valid);

    a_r6_busy_load_ignored: assert property (@(posedge clk) disable iff (rst)
        (wg_valid && load) |=> $stable(num_wg_total) && $stable(num_wg_x));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        kernel_done |=> !kernel_done);

    a_r9_after_dispatch: assert property (@(posedge clk) disable iff (rst)
        kernel_done |-> disp_done);

    a_r10_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !wg_valid);
endmodule

bind wg_grid_sequencer wgs_checker #(.CNT_W(CNT_W)) u_wgs_chk (
    .clk          (clk),
    .rst          (rst),
    .load         (load),
    .wg_valid     (wg_valid),
    .wg_ready     (wg_ready),
    .wg_id_x      (wg_id_x),
    .wg_id_y      (wg_id_y),
    .wg_id_z      (wg_id_z),
    .wg_flat      (wg_flat),
    .num_wg_x     (num_wg_x),
    .num_wg_y     (num_wg_y),
    .num_wg_z     (num_wg_z),
    .num_wg_total (num_wg_total),
    .disp_done    (disp_done),
    .kernel_done  (kernel_done),
    .cfg_err      (cfg_err)
);

// File: tb/wg_grid_sequencer_tb_top.sv
module wg_grid_sequencer_tb_top;
    localparam int SW  = 16;
    localparam int CW  = 16;
    localparam int RW  = 12;
    localparam int VGW = 6;
    localparam int SGW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [SW-1:0] grid_x = '0, grid_y = '0, grid_z = '0;
    logic [SW-1:0] wgsz_x = '0, wgsz_y = '0, wgsz_z = '0;
    logic [RW-1:0] vreg_explicit = '0, sreg_explicit = '0;
    logic [VGW-1:0] vreg_granule = '0;
    logic [SGW-1:0] sreg_granule = '0;
    logic wg_ready = 1'b0;
    logic wg_done = 1'b0;
    logic wg_valid, disp_done, kernel_done, cfg_err;
    logic [CW-1:0] wg_id_x, wg_id_y, wg_id_z, wg_flat;
    logic [CW-1:0] num_wg_x, num_wg_y, num_wg_z, num_wg_total;
    logic [RW-1:0] vreg_budget, sreg_budget;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wg_grid_sequencer #(.SIZE_W(SW), .CNT_W(CW), .REG_W(RW),
                        .VGRAN_W(VGW), .SGRAN_W(SGW)) dut_i (
        .clk(clk), .rst(rst), .load(load),
        .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
        .wgsz_x(wgsz_x), .wgsz_y(wgsz_y), .wgsz_z(wgsz_z),
        .vreg_explicit(vreg_explicit), .vreg_granule(vreg_granule),
        .sreg_explicit(sreg_explicit), .sreg_granule(sreg_granule),
        .wg_ready(wg_ready), .wg_done(wg_done), .wg_valid(wg_valid),
        .wg_id_x(wg_id_x), .wg_id_y(wg_id_y), .wg_id_z(wg_id_z),
        .wg_flat(wg_flat), .num_wg_x(num_wg_x), .num_wg_y(num_wg_y),
        .num_wg_z(num_wg_z), .num_wg_total(num_wg_total),
        .vreg_budget(vreg_budget), .sreg_budget(sreg_budget),
        .disp_done(disp_done), .kernel_done(kernel_done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    task automatic do_load(input int gx, input int gy, input int gz,
                           input int sx, input int sy, input int sz,
                           input int ve, input int vg, input int se, input int sg);
        grid_x = SW'(gx); grid_y = SW'(gy); grid_z = SW'(gz);
        wgsz_x = SW'(sx); wgsz_y = SW'(sy); wgsz_z = SW'(sz);
        vreg_explicit = RW'(ve); vreg_granule = VGW'(vg);
        sreg_explicit = RW'(se); sreg_granule = SGW'(sg);
        load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    // Reports every completion and checks the finish pulse timing (R9).
    task automatic t_complete(input int total);
        for (int i = 0; i < total; i++) begin
            wg_done = 1'b1;
            tick();
            check(kernel_done == 1'b0, "R9", "no early kernel_done", int'(kernel_done), 0);
        end
        wg_done = 1'b0;
        tick();
        check(kernel_done == 1'b1, "R9", "kernel_done pulse", int'(kernel_done), 1);
        tick();
        check(kernel_done == 1'b0, "R9", "kernel_done one cycle", int'(kernel_done), 0);
    endtask

    // Loads a kernel, walks all workgroups in X-fastest order, completes it.
    task automatic t_walk(input int gx, input int gy, input int gz,
                          input int sx, input int sy, input int sz,
                          input int ve, input int vg, input int se, input int sg,
                          input int exp_v, input int exp_s);
        int nx, ny, nz, flat;
        nx = cdiv(gx, sx); ny = cdiv(gy, sy); nz = cdiv(gz, sz);
        do_load(gx, gy, gz, sx, sy, sz, ve, vg, se, sg);
        check(int'(num_wg_x) == nx, "R2", "num_wg_x", int'(num_wg_x), nx);
        check(int'(num_wg_y) == ny, "R2", "num_wg_y", int'(num_wg_y), ny);
        check(int'(num_wg_z) == nz, "R2", "num_wg_z", int'(num_wg_z), nz);
        check(int'(num_wg_total) == nx*ny*nz, "R2", "num_wg_total", int'(num_wg_total), nx*ny*nz);
        check(int'(vreg_budget) == exp_v, "R7", "vreg_budget", int'(vreg_budget), exp_v);
        check(int'(sreg_budget) == exp_s, "R8", "sreg_budget", int'(sreg_budget), exp_s);
        wg_ready = 1'b1;
        flat = 0;
        for (int z = 0; z < nz; z++) begin
            for (int y = 0; y < ny; y++) begin
                for (int x = 0; x < nx; x++) begin
                    check(wg_valid == 1'b1, "R3", "valid during walk", int'(wg_valid), 1);
                    check(int'(wg_id_x) == x, "R3", "id_x", int'(wg_id_x), x);
                    check(int'(wg_id_y) == y, "R3", "id_y", int'(wg_id_y), y);
                    check(int'(wg_id_z) == z, "R3", "id_z", int'(wg_id_z), z);
                    check(int'(wg_flat) == flat, "R3", "flat index", int'(wg_flat), flat);
                    if (flat % 5 == 2) begin
                        wg_ready = 1'b0;
                        tick();
                        tick();
                        check(wg_valid == 1'b1, "R4", "valid held", int'(wg_valid), 1);
                        check(int'(wg_id_x) == x && int'(wg_id_y) == y && int'(wg_id_z) == z,
                              "R4", "ids held (x)", int'(wg_id_x), x);
                        check(int'(wg_flat) == flat, "R4", "flat held", int'(wg_flat), flat);
                        wg_ready = 1'b1;
                    end
                    tick();
                    flat++;
                end
            end
        end
        wg_ready = 1'b0;
        check(wg_valid == 1'b0, "R5", "valid low after last", int'(wg_valid), 0);
        check(disp_done == 1'b1, "R5", "disp_done set", int'(disp_done), 1);
        t_complete(nx*ny*nz);
    endtask

    task automatic t_reset();
        check(wg_valid == 1'b0, "R1", "reset valid", int'(wg_valid), 0);
        check(disp_done == 1'b0, "R1", "reset disp_done", int'(disp_done), 0);
        check(kernel_done == 1'b0, "R1", "reset kernel_done", int'(kernel_done), 0);
        check(cfg_err == 1'b0, "R1", "reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_busy_load();
        do_load(4, 4, 1, 1, 1, 1, 10, 0, 10, 0);
        check(int'(num_wg_total) == 16, "R2", "busy kernel total", int'(num_wg_total), 16);
        do_load(9, 9, 9, 2, 2, 2, 20, 0, 20, 0);
        check(int'(num_wg_total) == 16, "R6", "total unchanged", int'(num_wg_total), 16);
        check(int'(num_wg_x) == 4, "R6", "num_wg_x unchanged", int'(num_wg_x), 4);
        check(int'(vreg_budget) == 10, "R6", "budget unchanged", int'(vreg_budget), 10);
        check(wg_valid == 1'b1 && wg_flat == '0, "R6", "walk not restarted", int'(wg_flat), 0);
        wg_ready = 1'b1;
        repeat (16) tick();
        wg_ready = 1'b0;
        check(disp_done == 1'b1, "R5", "busy kernel drained", int'(disp_done), 1);
        t_complete(16);
    endtask

    task automatic t_fault();
        do_load(8, 8, 8, 2, 0, 2, 10, 0, 10, 0);
        check(cfg_err == 1'b1, "R10", "zero wg extent flagged", int'(cfg_err), 1);
        check(wg_valid == 1'b0, "R10", "no dispatch on fault", int'(wg_valid), 0);
        tick();
        check(wg_valid == 1'b0, "R10", "still no dispatch", int'(wg_valid), 0);
        do_load(0, 1, 1, 1, 1, 1, 10, 0, 10, 0);
        check(cfg_err == 1'b1, "R10", "zero grid extent flagged", int'(cfg_err), 1);
        do_load(2, 2, 1, 1, 1, 1, 10, 0, 10, 0);
        check(cfg_err == 1'b0, "R10", "fault cleared", int'(cfg_err), 0);
        check(wg_valid == 1'b1, "R10", "dispatch resumes", int'(wg_valid), 1);
        wg_ready = 1'b1;
        repeat (4) tick();
        wg_ready = 1'b0;
        t_complete(4);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        // Partial edges, both wraps, explicit register counts.
        t_walk(5, 3, 2, 2, 2, 1, 40, 7, 17, 2, 40, 17);
        // Exact fit, granule fallback.
        t_walk(4, 1, 1, 2, 1, 1, 0, 5, 0, 3, 24, 32);
        // Single workgroup, largest granules.
        t_walk(1, 1, 1, 4, 4, 4, 0, 63, 0, 15, 256, 128);
        t_busy_load();
        t_fault();
        finish_run();
    end
endmodule